// File: doc/BRIEF.md
# Interleaved Multi-Bank Block Memory

This block is a block-granular memory split into several independent banks behind one request port and one return bus. Consecutive block addresses land in consecutive banks, so a stream of sequential reads starts a row access in a new bank on every cycle. Only the transfer of each block over the shared return bus has to wait its turn.

A requester offers a block address with a valid/ready handshake. A request is held off only while its own bank is still occupied. A read costs one cycle to present the address. It then takes a fixed row-access time inside the bank, followed by a fixed number of data beats on the shared bus. Read data always leaves in the order the reads were accepted. A bank whose row access finishes early keeps its block until the bus reaches it. Writes carry a whole block, occupy their bank for the row-access time and return nothing.

Top module: `ilv_mem_top`

## Requirements
- R1: Block address A is held in bank A mod NUM_BANKS at in-bank index A div NUM_BANKS. The bank is the low log2(NUM_BANKS) address bits and the index is the remaining upper bits. Writing one address never changes the block read back from another address.
- R2: A read accepted in cycle c to an idle bank with an empty return bus presents its first beat in cycle c+1+ROW_LAT (c+11 by default). Its beats occupy consecutive cycles.
- R3: A block is returned as BEATS beats of BEAT_W bits, least-significant beat first. `resp_last` is high on the final beat only.
- R4: Read blocks are returned in the order the reads were accepted, whatever bank they come from.
- R5: Eight reads to eight consecutive addresses, issued one per cycle, complete in 43 cycles by default. The count runs from the first accept cycle to the last beat inclusive, giving (1+ROW_LAT+BEATS)+7*BEATS.
- R6: Eight reads that all map to one bank complete in 120 cycles by default, which is 8*(1+ROW_LAT+BEATS). While a request's bank is busy, `req_ready` is low.
- R7: A bank serving a read stays busy until its last beat leaves. A following request to that bank is accepted in the cycle right after that last beat, which is 1+ROW_LAT+BEATS cycles after the first accept.
- R8: A write stores its block, keeps its bank busy for ROW_LAT cycles, and produces no beat on the return bus. A second request to the same bank is accepted 1+ROW_LAT cycles after the write.
- R9: Out of reset, `req_ready` is high for any address and `resp_valid` is low.
- R10: When the next block in order is already waiting in its bank, its first beat follows the previous block's last beat with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bank of `req_addr` is free; request taken this cycle if valid |
| req_addr | input | ADDR_W | Block address |
| req_we | input | 1 | 1 = write block, 0 = read block |
| req_wdata | input | BEAT_W*BEATS | Write block, beat 0 in the low bits |
| resp_valid | output | 1 | A read beat is on `resp_data` |
| resp_data | output | BEAT_W | Read beat |
| resp_last | output | 1 | Final beat of a block |

## Verification
The sequential burst tests target bank overlap. A design that serialises row accesses, or that inserts a gap between blocks on the bus, misses the 43-cycle figure. The same-bank bursts and the back-to-back same-bank pair target the release point of a busy bank. A design that releases the bank too early accepts a second read before the first has drained, and one that releases it too late stretches the 120-cycle figure. Bursts whose addresses wrap across the bank count, and overwrites of two addresses sharing a bank, expose a swapped bank/index split or a response order broken by a faster bank. The write tests show whether a write leaks beats onto the return bus or holds its bank for the wrong number of cycles.

// File: rtl/ilv_pkg.sv
// Shared types of the interleaved memory.
// Assumes nothing beyond being compiled before the modules that use it.
package ilv_pkg;

    // Life cycle of one bank
    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,   // free, may take a request
        BK_ROW  = 2'd1,   // row access in progress
        BK_HOLD = 2'd2    // read block parked, waiting for the bus
    } bank_state_e;

endpackage

// File: rtl/ilv_bank.sv
// One memory bank: behavioural block storage plus a row-access timer.
// A read copies the block into a row buffer at accept. The bank then counts
// ROW_LAT cycles and parks the block until the bus drains it.
// A write stores at accept and frees the bank after ROW_LAT cycles.
// Assumes acc_en is raised only while busy is low.
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int BLK_W   = 64,
    parameter int ROW_LAT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_we,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [BLK_W-1:0] acc_wdata,
    input  logic             drain_done,
    output logic             busy,
    output logic             row_rdy,
    output logic [BLK_W-1:0] row_data
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int CNT_W = $clog2(ROW_LAT + 1);

    logic [BLK_W-1:0] cells [DEPTH];
    logic [BLK_W-1:0] row_q;
    bank_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_wr_q;

    // Storage update on an accepted write
    always_ff @(posedge clk) begin
        if (acc_en && acc_we) begin
            cells[acc_idx] <= acc_wdata;
        end
    end

    // Row buffer load on an accepted read
    always_ff @(posedge clk) begin
        if (acc_en && !acc_we) begin
            row_q <= cells[acc_idx];
        end
    end

    // Bank state sequencing: idle -> row access -> (hold) -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
            is_wr_q <= 1'b0;
        end else begin
            case (state_q)
                BK_IDLE: begin
                    if (acc_en) begin
                        state_q <= BK_ROW;
                        cnt_q   <= CNT_W'(ROW_LAT - 1);
                        is_wr_q <= acc_we;
                    end
                end
                BK_ROW: begin
                    if (cnt_q == '0) begin
                        state_q <= is_wr_q ? BK_IDLE : BK_HOLD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                BK_HOLD: begin
                    if (drain_done) begin
                        state_q <= BK_IDLE;
                    end
                end
                default: state_q <= BK_IDLE;
            endcase
        end
    end

    // Status seen by the request side and the bus
    always_comb begin
        busy     = (state_q != BK_IDLE);
        row_rdy  = (state_q == BK_HOLD);
        row_data = row_q;
    end

endmodule

// File: rtl/ilv_order_q.sv
// In-order queue of bank numbers for accepted reads.
// Assumes DEPTH is a power of two, at least 2, and never exceeded. With one
// read per bank in flight, DEPTH = bank count suffices.
module ilv_order_q #(
    parameter int ENTRY_W = 3,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_val,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head,
    output logic               empty
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [ENTRY_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]   wr_q;
    logic [PTR_W-1:0]   rd_q;
    logic [PTR_W:0]     cnt_q;

    // Slot write on push
    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_q] <= push_val;
        end
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Oldest entry and empty flag
    always_comb begin
        head  = slots[rd_q];
        empty = (cnt_q == '0);
    end

endmodule

// File: rtl/ilv_beat_bus.sv
// Shared return bus: streams the block of the oldest read, beat 0 first,
// once its bank has parked the block. A parked bank waits for its turn.
// Assumes row_rdy of the head bank stays high until drain_done is returned.
module ilv_beat_bus #(
    parameter int NUM_BANKS = 8,
    parameter int BEAT_W    = 16,
    parameter int BEATS     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         q_empty,
    input  logic [$clog2(NUM_BANKS)-1:0] head_bank,
    input  logic [NUM_BANKS-1:0]         row_rdy,
    input  logic [BEAT_W*BEATS-1:0]      row_data [NUM_BANKS],
    output logic                         resp_valid,
    output logic [BEAT_W-1:0]            resp_data,
    output logic                         resp_last,
    output logic                         pop,
    output logic [NUM_BANKS-1:0]         drain_done
);
    localparam int BLK_W  = BEAT_W * BEATS;
    localparam int BEAT_CW = $clog2(BEATS);

    logic [BEAT_CW-1:0] beat_q;
    logic [BLK_W-1:0]   sel_blk;
    logic               active;
    logic               at_end;

    // Beat position within the block on the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (active) begin
            beat_q <= at_end ? '0 : beat_q + 1'b1;
        end
    end

    // Beat selection and bank release
    always_comb begin
        sel_blk    = row_data[head_bank];
        active     = !q_empty && row_rdy[head_bank];
        at_end     = (beat_q == BEAT_CW'(BEATS - 1));
        resp_valid = active;
        resp_data  = sel_blk[beat_q*BEAT_W +: BEAT_W];
        resp_last  = active && at_end;
        pop        = active && at_end;
        drain_done = pop ? (NUM_BANKS'(1) << head_bank) : '0;
    end

endmodule

// File: rtl/ilv_mem_top.sv
// Interleaved block memory top. Low address bits pick the bank and the upper
// bits pick the block within it. The request port stalls only on a busy
// target bank. Read data returns on one shared bus in accept order.
// Assumes NUM_BANKS and BEATS are powers of two, at least 2.
module ilv_mem_top
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 8,
    parameter int BEAT_W    = 16,
    parameter int BEATS     = 4,
    parameter int ROW_LAT   = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_we,
    input  logic [BEAT_W*BEATS-1:0] req_wdata,
    output logic                    resp_valid,
    output logic [BEAT_W-1:0]       resp_data,
    output logic                    resp_last
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int IDX_W  = ADDR_W - BANK_W;
    localparam int BLK_W  = BEAT_W * BEATS;

    logic [BANK_W-1:0]    bank_sel;
    logic [IDX_W-1:0]     bank_idx;
    logic                 take;
    logic [NUM_BANKS-1:0] busy;
    logic [NUM_BANKS-1:0] row_rdy;
    logic [NUM_BANKS-1:0] drain_done;
    logic [BLK_W-1:0]     row_data [NUM_BANKS];
    logic [BANK_W-1:0]    head_bank;
    logic                 q_empty;
    logic                 pop;

    // Address split and request acceptance
    always_comb begin
        bank_sel  = req_addr[BANK_W-1:0];
        bank_idx  = req_addr[ADDR_W-1:BANK_W];
        req_ready = !busy[bank_sel];
        take      = req_valid && req_ready;
    end

    // One bank per interleave slot
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ilv_bank #(
            .IDX_W  (IDX_W),
            .BLK_W  (BLK_W),
            .ROW_LAT(ROW_LAT)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_en    (take && (bank_sel == BANK_W'(b))),
            .acc_we    (req_we),
            .acc_idx   (bank_idx),
            .acc_wdata (req_wdata),
            .drain_done(drain_done[b]),
            .busy      (busy[b]),
            .row_rdy   (row_rdy[b]),
            .row_data  (row_data[b])
        );
    end

    ilv_order_q #(
        .ENTRY_W(BANK_W),
        .DEPTH  (NUM_BANKS)
    ) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (take && !req_we),
        .push_val(bank_sel),
        .pop     (pop),
        .head    (head_bank),
        .empty   (q_empty)
    );

    ilv_beat_bus #(
        .NUM_BANKS(NUM_BANKS),
        .BEAT_W   (BEAT_W),
        .BEATS    (BEATS)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_empty   (q_empty),
        .head_bank (head_bank),
        .row_rdy   (row_rdy),
        .row_data  (row_data),
        .resp_valid(resp_valid),
        .resp_data (resp_data),
        .resp_last (resp_last),
        .pop       (pop),
        .drain_done(drain_done)
    );

endmodule

// File: rtl/ilv_mem_chk.sv
// Port-level checker for ilv_mem_top, attached by bind below.
// Tracks outstanding reads and beat position from the ports alone.
module ilv_mem_chk #(
    parameter int NUM_BANKS = 8,
    parameter int BEATS     = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_we,
    input logic resp_valid,
    input logic resp_last
);
    localparam int OUT_W = $clog2(NUM_BANKS + 1) + 1;
    localparam int BC_W  = $clog2(BEATS) + 1;

    logic [OUT_W-1:0] outst_q;
    logic [BC_W-1:0]  beat_q;
    logic             rd_take;
    logic             wr_take;

    always_comb begin
        rd_take = req_valid && req_ready && !req_we;
        wr_take = req_valid && req_ready && req_we;
    end

    // Reads accepted minus blocks completed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= '0;
        end else begin
            outst_q <= outst_q + OUT_W'(rd_take) - OUT_W'(resp_valid && resp_last);
        end
    end

    // Beats seen in the current block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (resp_valid) begin
            beat_q <= resp_last ? '0 : beat_q + 1'b1;
        end
    end

    p_last_on_final_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_last) |-> (beat_q == BC_W'(BEATS - 1)));

    p_final_beat_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && beat_q == BC_W'(BEATS - 1)) |-> resp_last);

    p_no_orphan_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (outst_q != '0));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q <= OUT_W'(NUM_BANKS));

    p_no_instant_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && outst_q == '0) |=> !resp_valid);

    p_write_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && outst_q == '0) |=> !resp_valid);

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> !resp_valid);

endmodule

bind ilv_mem_top ilv_mem_chk #(
    .NUM_BANKS(NUM_BANKS),
    .BEATS    (BEATS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .resp_valid(resp_valid),
    .resp_last (resp_last)
);

// File: tb/test_ilv_mem_top.sv
// Bench for ilv_mem_top: fills memory, walks a burst table, then runs
// directed reset, latency, busy-release and write tests.
module test_ilv_mem_top;
    localparam int CLK_P = 10;
    localparam int NB    = 8;
    localparam int AW    = 8;
    localparam int BW    = 16;
    localparam int NBT   = 4;
    localparam int RL    = 10;
    localparam int NVEC  = 7;
    // {start address, stride, block count, expected total cycles}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd0,   8'd1,  8'd8, 8'd43},
        {8'd3,   8'd1,  8'd8, 8'd43},
        {8'd8,   8'd8,  8'd8, 8'd120},
        {8'd16,  8'd2,  8'd4, 8'd27},
        {8'd5,   8'd8,  8'd2, 8'd30},
        {8'd200, 8'd1,  8'd1, 8'd15},
        {8'd77,  8'd16, 8'd3, 8'd45}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [AW-1:0]     req_addr = '0;
    logic              req_we = 1'b0;
    logic [BW*NBT-1:0] req_wdata = '0;
    logic              resp_valid;
    logic [BW-1:0]     resp_data;
    logic              resp_last;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int nb    = 0;
    logic [BW-1:0] bdat [512];
    logic          blst [512];
    int            bcyc [512];

    ilv_mem_top #(
        .NUM_BANKS(NB), .ADDR_W(AW), .BEAT_W(BW), .BEATS(NBT), .ROW_LAT(RL)
    ) i_ilv_mem_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_last(resp_last)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Beat capture away from the active edge
    always @(negedge clk) begin
        if (rst_n && resp_valid && nb < 512) begin
            bdat[nb] = resp_data;
            blst[nb] = resp_last;
            bcyc[nb] = cyc;
            nb = nb + 1;
        end
    end

    function automatic logic [BW*NBT-1:0] pat(input logic [AW-1:0] a);
        logic [BW*NBT-1:0] v;
        for (int j = 0; j < NBT; j++) v[j*BW +: BW] = {a, 8'(j * 17 + 3)};
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [AW-1:0] a, input logic we,
                          input logic [BW*NBT-1:0] wd, output int acc);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
        #(CLK_P/4);
        while (!req_ready) begin
            @(negedge clk);
            #(CLK_P/4);
        end
        acc = cyc;
        @(posedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_beats(input int target);
        int guard = 0;
        while (nb < target && guard < 400) begin
            @(posedge clk);
            guard++;
        end
        repeat (2) @(posedge clk);
    endtask

    // Compare captured block k of a run with an expected block
    task automatic chk_block(input int base, input logic [BW*NBT-1:0] exp_blk,
                             input string req);
        int errs = 0;
        for (int j = 0; j < NBT; j++) begin
            if (bdat[base + j] !== exp_blk[j*BW +: BW]) errs++;
            if (blst[base + j] !== (j == NBT - 1)) errs++;
        end
        chk(errs == 0, req, errs, 0);
    endtask

    initial begin
        int c0, c1, c2, n0;
        logic [BW*NBT-1:0] nv1, nv2;

        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk(req_ready === 1'b1, "R9 ready in reset", int'(req_ready), 1);
        chk(resp_valid === 1'b0, "R9 resp_valid in reset", int'(resp_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && resp_valid === 1'b0, "R9 idle after reset",
            int'(resp_valid), 0);

        // Fill every block with its own pattern
        for (int a = 0; a < (1 << AW); a++) do_req(AW'(a), 1'b1, pat(AW'(a)), c0);
        go_idle();
        repeat (RL + 4) @(posedge clk);

        // Burst table: R1, R3, R4, R5, R6, R10
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] st, sd, cn, ex;
            int first_acc;
            {st, sd, cn, ex} = VEC[v];
            n0 = nb;
            for (int k = 0; k < int'(cn); k++) begin
                do_req(AW'(st + sd * k), 1'b0, '0, c0);
                if (k == 0) first_acc = c0;
            end
            go_idle();
            wait_beats(n0 + int'(cn) * NBT);
            chk(nb == n0 + int'(cn) * NBT, "R3 beat count", nb - n0, int'(cn) * NBT);
            // R5 / R6 / R10: overlapped or serialised total
            chk(bcyc[n0 + int'(cn) * NBT - 1] - first_acc + 1 == int'(ex),
                "R5 R6 R10 burst cycles",
                bcyc[n0 + int'(cn) * NBT - 1] - first_acc + 1, int'(ex));
            // R1 / R4: data from the right bank and index, in order
            for (int k = 0; k < int'(cn); k++)
                chk_block(n0 + k * NBT, pat(AW'(st + sd * k)), "R1 R4 burst data");
        end

        // R2: latency from accept to first beat
        n0 = nb;
        do_req(8'd0, 1'b0, '0, c0);
        go_idle();
        wait_beats(n0 + NBT);
        chk(bcyc[n0] == c0 + 1 + RL, "R2 first beat cycle", bcyc[n0] - c0, 1 + RL);
        chk(bcyc[n0 + NBT - 1] == bcyc[n0] + NBT - 1, "R2 consecutive beats",
            bcyc[n0 + NBT - 1] - bcyc[n0], NBT - 1);

        // R7: same-bank read accepted right after last beat
        n0 = nb;
        do_req(8'd1, 1'b0, '0, c1);
        do_req(8'd9, 1'b0, '0, c2);
        go_idle();
        wait_beats(n0 + 2 * NBT);
        chk(c2 - c1 == 1 + RL + NBT, "R7 same-bank accept gap", c2 - c1, 1 + RL + NBT);
        chk(c2 == bcyc[n0 + NBT - 1] + 1, "R7 accept after last beat",
            c2 - bcyc[n0 + NBT - 1], 1);
        chk_block(n0, pat(8'd1), "R7 first block");
        chk_block(n0 + NBT, pat(8'd9), "R7 second block");

        // R8: writes occupy ROW_LAT cycles and return nothing
        nv1 = ~pat(8'd10);
        nv2 = pat(8'd18) ^ 64'h0F0F_1234_5678_9ABC;
        n0 = nb;
        do_req(8'd10, 1'b1, nv1, c1);
        do_req(8'd18, 1'b1, nv2, c2);
        go_idle();
        repeat (RL + 6) @(posedge clk);
        chk(c2 - c1 == 1 + RL, "R8 write occupancy", c2 - c1, 1 + RL);
        chk(nb == n0, "R8 write returns no beats", nb - n0, 0);

        // R1 / R4: overwritten blocks and their bank neighbour
        n0 = nb;
        do_req(8'd10, 1'b0, '0, c0);
        do_req(8'd18, 1'b0, '0, c0);
        do_req(8'd2, 1'b0, '0, c0);
        do_req(8'd11, 1'b0, '0, c0);
        go_idle();
        wait_beats(n0 + 4 * NBT);
        chk_block(n0, nv1, "R8 written block 10");
        chk_block(n0 + NBT, nv2, "R8 written block 18");
        chk_block(n0 + 2 * NBT, pat(8'd2), "R1 untouched block 2");
        chk_block(n0 + 3 * NBT, pat(8'd11), "R4 order after same-bank reads");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule